// File: doc/BRIEF.md
# Overcurrent Fault Latch Gate

This block sits between general-purpose output data bits and the enable pins of external power switches: a bank of high-side switches (one by default) and a bank of low-side switches (four by default). The current-limit hardware reports trouble on an active-low trip line. Any change of level on that line, falling or rising, is taken as a fault and sets a sticky fault flag. While the flag is set, every switch enable is held off, whatever the output data asks for.

The flag is released only by a rising edge on a separate clear line; holding the clear line high does nothing more. Both the trip line and the clear line are asynchronous to the block clock and pass through a synchronizer chain before edge detection. The flag is brought out as a status level that software may poll or route to an interrupt controller. When no fault is latched, each enable is a registered copy of its data bit.

Top module: `ocp_fault_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the fault flag is 0 and every switch enable is 0.
- R2: A falling edge on the trip line sets the fault flag; with the default two-stage synchronizer, a change applied before clock edge k is seen on the flag after edge k+2.
- R3: A rising edge on the trip line sets the fault flag with the same latency as R2, so a pulse of either polarity trips the latch.
- R4: Once set, the fault flag stays 1 while the trip line is steady and the clear line shows no rising edge, including while the clear line is held high.
- R5: A rising edge on the clear line clears the fault flag with the same latency as R2.
- R6: When a trip edge and a clear rising edge are detected in the same cycle, the fault flag is 1 after that cycle.
- R7: While the fault flag is 1, all high-side and low-side enables are 0 regardless of the data bits; the enables go to 0 in the same cycle the flag rises.
- R8: While no fault is latched, each enable equals its data bit as sampled at the previous clock edge (one cycle of latency); bit i of the low-side data drives bit i of the low-side enables, likewise for the high side.
- R9: A trip-line or clear-line level that differs from the idle level while reset is held causes no fault and no clear at reset release.
- R10: A falling edge on the clear line has no effect on the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_n_in | input | 1 | Active-low fault line from the current-limit hardware, asynchronous |
| clear_in | input | 1 | Fault clear line, rising edge clears, asynchronous |
| gpio_hs_data | input | N_HS | Requested state of the high-side switch enables |
| gpio_ls_data | input | N_LS | Requested state of the low-side switch enables |
| hs_en | output | N_HS | High-side switch enables, registered |
| ls_en | output | N_LS | Low-side switch enables, registered |
| fault_flag | output | 1 | Latched fault status, registered |

## Verification
The bench drives the latch with a falling trip edge, a rising trip edge and a one-cycle trip glitch, which tells a level-sensitive or single-polarity detector apart from one that trips on any change. The clear line is exercised with a held-high level, a falling edge and a rising edge, and once coincident with a trip edge, separating edge-triggered clearing from level clearing and checking the fault-over-clear priority. Data bits are walked and randomised both with and without a latched fault, which exposes bit swaps, missing gating and a gate that lags the flag. A non-idle trip level held through reset checks that the detectors start from the synchronized level rather than an assumed one.

// File: rtl/ocp_gate_pkg.sv
package ocp_gate_pkg;

  // Default geometry of the switch banks and the synchronizer.
  localparam int unsigned DEF_N_HS        = 1;
  localparam int unsigned DEF_N_LS        = 4;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Bit positions of the two control lines inside the shared synchronizer.
  localparam int unsigned CTL_TRIP  = 0;
  localparam int unsigned CTL_CLEAR = 1;
  localparam int unsigned CTL_W     = 2;

  // Which edges count for each control line: trip takes both, clear only rising.
  localparam logic [CTL_W-1:0] CTL_BOTH_EDGES = 2'b01;

  typedef enum logic [1:0] {
    LATCH_HOLD  = 2'b00,
    LATCH_SET   = 2'b01,
    LATCH_CLEAR = 2'b10
  } latch_op_e;

endpackage

// File: rtl/ocp_sync.sv
module ocp_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  // During reset every stage is flushed with the raw input, so the chain
  // leaves reset already holding one consistent level.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= d;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[LAST];

endmodule

// File: rtl/ocp_edge_det.sv
module ocp_edge_det #(
  parameter int unsigned      WIDTH      = 2,
  parameter logic [WIDTH-1:0] BOTH_EDGES = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] ev
);

  logic [WIDTH-1:0] prev_q;

  // The previous-level register tracks the synchronized level through reset,
  // so the first cycle after release compares like with like.
  always_ff @(posedge clk) begin
    prev_q <= lvl;
  end

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (BOTH_EDGES[i]) begin : g_any
        assign ev[i] = !rst && (lvl[i] != prev_q[i]);
      end else begin : g_rise
        assign ev[i] = !rst && lvl[i] && !prev_q[i];
      end
    end
  endgenerate

endmodule

// File: rtl/ocp_trip_latch.sv
module ocp_trip_latch
  import ocp_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_ev,
  output logic flag_d,
  output logic flag_q
);

  latch_op_e op;

  // Set has priority: a fault seen in the same cycle as a clear must not be lost.
  always_comb begin
    if (set_ev)      op = LATCH_SET;
    else if (clr_ev) op = LATCH_CLEAR;
    else             op = LATCH_HOLD;
  end

  always_comb begin
    unique case (op)
      LATCH_SET:   flag_d = 1'b1;
      LATCH_CLEAR: flag_d = 1'b0;
      default:     flag_d = flag_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_d;
  end

endmodule

// File: rtl/ocp_en_gate.sv
module ocp_en_gate #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             block,
  input  logic [WIDTH-1:0] data,
  output logic [WIDTH-1:0] en
);

  logic [WIDTH-1:0] en_q;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_sw
      always_ff @(posedge clk) begin
        if (rst) en_q[i] <= 1'b0;
        else     en_q[i] <= data[i] && !block;
      end
    end
  endgenerate

  assign en = en_q;

endmodule

// File: rtl/ocp_fault_gate.sv
module ocp_fault_gate
  import ocp_gate_pkg::*;
#(
  parameter int unsigned N_HS        = DEF_N_HS,
  parameter int unsigned N_LS        = DEF_N_LS,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            trip_n_in,
  input  logic            clear_in,
  input  logic [N_HS-1:0] gpio_hs_data,
  input  logic [N_LS-1:0] gpio_ls_data,
  output logic [N_HS-1:0] hs_en,
  output logic [N_LS-1:0] ls_en,
  output logic            fault_flag
);

  localparam int unsigned N_SW = N_HS + N_LS;

  logic [CTL_W-1:0] ctl_raw;
  logic [CTL_W-1:0] ctl_sync;
  logic [CTL_W-1:0] ctl_ev;
  logic             trip_edge;
  logic             clr_rise;
  logic             flag_next;
  logic [N_SW-1:0]  sw_data;
  logic [N_SW-1:0]  sw_en;

  always_comb begin
    ctl_raw            = '0;
    ctl_raw[CTL_TRIP]  = trip_n_in;
    ctl_raw[CTL_CLEAR] = clear_in;
  end

  ocp_sync #(
    .STAGES (SYNC_STAGES),
    .WIDTH  (CTL_W)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_sync)
  );

  ocp_edge_det #(
    .WIDTH      (CTL_W),
    .BOTH_EDGES (CTL_BOTH_EDGES)
  ) u_edge (
    .clk (clk),
    .rst (rst),
    .lvl (ctl_sync),
    .ev  (ctl_ev)
  );

  assign trip_edge = ctl_ev[CTL_TRIP];
  assign clr_rise  = ctl_ev[CTL_CLEAR];

  ocp_trip_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .set_ev (trip_edge),
    .clr_ev (clr_rise),
    .flag_d (flag_next),
    .flag_q (fault_flag)
  );

  assign sw_data = {gpio_hs_data, gpio_ls_data};

  // The gate sees the latch's next value so the enables drop in the same
  // cycle the flag rises.
  ocp_en_gate #(
    .WIDTH (N_SW)
  ) u_gate (
    .clk   (clk),
    .rst   (rst),
    .block (flag_next),
    .data  (sw_data),
    .en    (sw_en)
  );

  assign hs_en = sw_en[N_SW-1:N_LS];
  assign ls_en = sw_en[N_LS-1:0];

endmodule

// File: rtl/ocp_fault_gate_chk.sv
module ocp_fault_gate_chk #(
  parameter int unsigned N_HS = 1,
  parameter int unsigned N_LS = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            trip_edge,
  input logic            clr_rise,
  input logic            fault_flag,
  input logic [N_HS-1:0] gpio_hs_data,
  input logic [N_LS-1:0] gpio_ls_data,
  input logic [N_HS-1:0] hs_en,
  input logic [N_LS-1:0] ls_en
);

  AST_TRIP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    trip_edge |=> fault_flag); // R2

  AST_FAULT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (trip_edge && clr_rise) |=> fault_flag); // R6

  AST_CLEAR_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (clr_rise && !trip_edge) |=> !fault_flag); // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fault_flag && !clr_rise) |=> fault_flag); // R4

  AST_FLAG_BLOCKS_EN: assert property (@(posedge clk) disable iff (rst)
    fault_flag |-> (hs_en == '0 && ls_en == '0)); // R7

  AST_EN_FOLLOWS_DATA: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !fault_flag |->
      (hs_en == $past(gpio_hs_data) && ls_en == $past(gpio_ls_data))); // R8

  AST_NO_SET_WITHOUT_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!fault_flag && !trip_edge) |=> !fault_flag); // R9

endmodule

bind ocp_fault_gate ocp_fault_gate_chk #(
  .N_HS (N_HS),
  .N_LS (N_LS)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .trip_edge    (trip_edge),
  .clr_rise     (clr_rise),
  .fault_flag   (fault_flag),
  .gpio_hs_data (gpio_hs_data),
  .gpio_ls_data (gpio_ls_data),
  .hs_en        (hs_en),
  .ls_en        (ls_en)
);

// File: tb/ocp_fault_gate_test.sv
module ocp_fault_gate_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_HS       = 1;
  localparam int N_LS       = 4;
  localparam int WATCHDOG   = 5000;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            trip_n_in = 1'b1;
  logic            clear_in  = 1'b0;
  logic [N_HS-1:0] gpio_hs_data = '0;
  logic [N_LS-1:0] gpio_ls_data = '0;
  logic [N_HS-1:0] hs_en;
  logic [N_LS-1:0] ls_en;
  logic            fault_flag;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_fault_gate #(.N_HS(N_HS), .N_LS(N_LS), .SYNC_STAGES(2)) uut (
    .clk, .rst, .trip_n_in, .clear_in, .gpio_hs_data, .gpio_ls_data,
    .hs_en, .ls_en, .fault_flag
  );

  // Reference model: raw input history as queues, flag and enables as ints.
  bit trip_hist[$];
  bit clr_hist[$];
  int m_flag = 0;
  int m_hs   = 0;
  int m_ls   = 0;

  always @(posedge clk) begin
    if (rst) begin
      trip_hist = {trip_n_in, trip_n_in, trip_n_in};
      clr_hist  = {clear_in, clear_in, clear_in};
      m_flag = 0; m_hs = 0; m_ls = 0;
    end else begin
      // index 0 newest: [0]=first stage, [1]=synchronized, [2]=previous level
      bit t_ev, c_ev;
      t_ev = trip_hist[1] != trip_hist[2];
      c_ev = clr_hist[1] && !clr_hist[2];
      if (t_ev)      m_flag = 1;
      else if (c_ev) m_flag = 0;
      m_hs = m_flag ? 0 : int'(gpio_hs_data);
      m_ls = m_flag ? 0 : int'(gpio_ls_data);
      trip_hist.push_front(trip_n_in); void'(trip_hist.pop_back());
      clr_hist.push_front(clear_in);   void'(clr_hist.pop_back());
    end
    cycles++;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Compare every output against the model, away from the active edge.
  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, "fault_flag", int'(fault_flag), m_flag);
      chk(tag, "hs_en", int'(hs_en), m_hs);
      chk(tag, "ls_en", int'(ls_en), m_ls);
    end
  endtask

  task automatic rand_data();
    gpio_hs_data = N_HS'($urandom);
    gpio_ls_data = N_LS'($urandom);
  endtask

  initial begin : watchdog
    wait (cycles > WATCHDOG);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1 and R9: non-idle trip level and high clear held through reset
    tag = "R1";
    trip_n_in = 1'b0; clear_in = 1'b1;
    gpio_hs_data = '1; gpio_ls_data = '1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", "flag in reset", int'(fault_flag), 0);
      chk("R1", "enables in reset", int'({hs_en, ls_en}), 0);
    end
    rst = 1'b0;
    tag = "R9";
    step(6);
    chk("R9", "no trip from reset level", int'(fault_flag), 0);

    // R8: pass-through with walking and random data
    tag = "R8";
    for (int b = 0; b < N_HS + N_LS; b++) begin
      {gpio_hs_data, gpio_ls_data} = (N_HS+N_LS)'(1) << b;
      step(1);
    end
    for (int i = 0; i < 12; i++) begin rand_data(); step(1); end
    gpio_hs_data = 1'b1; gpio_ls_data = 4'b0101;
    step(1); step(1);
    chk("R8", "ls_en bits", int'(ls_en), 5);
    chk("R8", "hs_en bit", int'(hs_en), 1);

    // R3: rising trip edge, enables drop the same cycle as the flag (R7)
    tag = "R3";
    trip_n_in = 1'b1;
    step(2);
    chk("R3", "flag before latency", int'(fault_flag), 0);
    step(1);
    chk("R3", "flag after rising trip", int'(fault_flag), 1);
    chk("R7", "enables with flag", int'({hs_en, ls_en}), 0);

    // R7: data cannot reach the switches while latched
    tag = "R7";
    for (int i = 0; i < 10; i++) begin rand_data(); step(1); end
    gpio_hs_data = '1; gpio_ls_data = '1;
    step(2);
    chk("R7", "all-ones data blocked", int'({hs_en, ls_en}), 0);

    // R4: clear held high (since reset) and steady trip: flag stays
    tag = "R4";
    step(6);
    chk("R4", "flag held", int'(fault_flag), 1);

    // R10: falling clear edge is ignored
    tag = "R10";
    clear_in = 1'b0;
    step(6);
    chk("R10", "flag after clear fall", int'(fault_flag), 1);

    // R5: rising clear edge releases, data passes again
    tag = "R5";
    clear_in = 1'b1;
    step(2);
    chk("R5", "flag before latency", int'(fault_flag), 1);
    step(1);
    chk("R5", "flag after clear rise", int'(fault_flag), 0);
    step(1);
    chk("R5", "enables restored", int'({hs_en, ls_en}), 31);

    // R2: falling trip edge sets
    tag = "R2";
    rand_data();
    trip_n_in = 1'b0;
    step(3);
    chk("R2", "flag after falling trip", int'(fault_flag), 1);
    clear_in = 1'b0; step(3);
    clear_in = 1'b1; step(4);
    chk("R5", "second release", int'(fault_flag), 0);

    // R2: one-cycle glitch on the trip line
    tag = "R2";
    trip_n_in = 1'b1; step(1);
    trip_n_in = 1'b0; step(5);
    chk("R2", "flag after glitch", int'(fault_flag), 1);
    clear_in = 1'b0; step(3);
    clear_in = 1'b1; step(4);
    chk("R5", "third release", int'(fault_flag), 0);

    // R6: trip edge and clear rise in the same cycle
    tag = "R6";
    clear_in = 1'b0; step(4);
    trip_n_in = 1'b1; clear_in = 1'b1;
    step(6);
    chk("R6", "fault wins over clear", int'(fault_flag), 1);
    chk("R6", "enables blocked", int'({hs_en, ls_en}), 0);

    // R1: reset mid-fault clears everything
    tag = "R1";
    rst = 1'b1;
    step(3);
    chk("R1", "flag after reset", int'(fault_flag), 0);
    rst = 1'b0;
    step(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule